// File: doc/BRIEF.md
# TDM Output Channel Delay Serializer

This block drives one serial output stream of a time-division multiplexed link. A bit-rate clock enable sets the bit rate. The block splits each frame into 8-bit channel slots and shifts each byte out most significant bit first. The bytes come from an external store through a one-cycle fetch interface. The block asks for a channel number and latches the byte returned in the same cycle.

A per-stream delay rotates the channel numbering against the shared output frame boundary. With a delay of N, channel 0 starts N slots after the boundary, and the last N channels of the frame fill the slots before it. The frame holds 32, 64 or 128 channels, chosen by a rate select. The delay is always taken modulo that count. The byte for the next slot is fetched partway through the current slot, so the serial stream has no gaps at slot boundaries.

A frame pulse that coincides with a bit enable re-aligns the stream to slot 0. Without frame pulses, the slot position wraps by itself once per frame.

Top module: `tdm_chdly_serializer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, ser_out and fetch_req are 0.
- R2: ser_out changes only on cycles with bit_en high. Each byte is sent bit 7 first, then down to bit 0, one bit per enable. There are no idle bits between slots.
- R3: With ch_delay 0, slot s carries channel s, so channel 0 is the first byte after a frame pulse.
- R4: With delay N, slot s carries channel (s − N) mod C. C is 32 for rate_sel 0, 64 for 1, and 128 for 2 or 3.
- R5: A ch_delay greater than C − 1 acts as ch_delay mod C.
- R6: fetch_req is high for exactly one cycle, in the cycle after the bit_en cycle that emits bit 4 (the fourth bit, position index 3) of a slot. fetch_chan then names the channel of the following slot. fetch_data is sampled in that same cycle.
- R7: When frame_pulse and bit_en are both high, the bit emitted is bit 7 of slot 0. That bit comes from the most recently prefetched byte.
- R8: Without frame pulses, the slot after slot C − 1 is slot 0.
- R9: If rate_sel is lowered while the slot position is at or above the new C − 1, the next slot is slot 0.
- R10: If a frame pulse with bit_en falls in a cycle where fetch_req is high, slot 0 takes the byte on fetch_data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One output bit per high cycle |
| frame_pulse | input | 1 | Output frame boundary, taken when bit_en is high |
| rate_sel | input | 2 | Channels per frame: 0=32, 1=64, 2/3=128 |
| ch_delay | input | 7 | Channel slot delay of this stream |
| fetch_req | output | 1 | Byte fetch strobe, one cycle |
| fetch_chan | output | 7 | Channel number being fetched |
| fetch_data | input | 8 | Byte for fetch_chan, valid while fetch_req is high |
| ser_out | output | 1 | Serial output data |

## Verification
Two functions can fall in the same cycle: the prefetch capture, and a re-alignment by a frame pulse that wants the byte for slot 0. The bench provokes this by issuing a frame pulse one bit after a fetch point, on an enable every cycle. The cycle-level reference model then expects slot 0 to carry the byte returned by that fetch. The same model is also run through a rate drop in the middle of a frame, to judge the forced wrap.

// File: rtl/tdm_dly_pkg.sv
// Shared constants and helpers for the channel delay serializer.
// Assumes power-of-two channel counts so modulo reduces to a mask.
package tdm_dly_pkg;
    parameter int BYTE_W = 8;
    parameter int SLOT_W = 7;
    parameter int RATE_W = 2;
    localparam int BIT_W = $clog2(BYTE_W);
    localparam int FETCH_BIT = 3;
    localparam int BASE_LOG = SLOT_W - 2;

    // Highest channel number for a rate code (channel count minus one).
    function automatic logic [SLOT_W-1:0] slot_mask(input logic [RATE_W-1:0] rate);
        logic [SLOT_W:0] cnt;
        case (rate)
            2'd0:    cnt = (SLOT_W+1)'(1) << BASE_LOG;
            2'd1:    cnt = (SLOT_W+1)'(1) << (BASE_LOG + 1);
            default: cnt = (SLOT_W+1)'(1) << SLOT_W;
        endcase
        return SLOT_W'(cnt - 1'b1);
    endfunction

    // Slot that follows s, wrapping at or above the frame end.
    function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s,
                                                    input logic [RATE_W-1:0] rate);
        return (s >= slot_mask(rate)) ? '0 : s + 1'b1;
    endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
// Tracks bit and slot position within the output frame.
// Assumes frame_pulse counts only in cycles where bit_en is high.
module tdm_slot_timer
    import tdm_dly_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_pulse,
    input  logic [RATE_W-1:0] rate_sel,
    output logic [BIT_W-1:0]  cur_bit,
    output logic [SLOT_W-1:0] cur_slot
);
    logic [BIT_W-1:0]  nxt_bit;
    logic [SLOT_W-1:0] nxt_slot;

    // Position of the bit emitted on this enable; a frame pulse forces slot 0.
    always_comb begin
        cur_bit  = frame_pulse ? '0 : nxt_bit;
        cur_slot = frame_pulse ? '0 : nxt_slot;
    end

    // Advance the position by one bit per enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_bit  <= '0;
            nxt_slot <= '0;
        end else if (bit_en) begin
            if (cur_bit == BIT_W'(BYTE_W - 1)) begin
                nxt_bit  <= '0;
                nxt_slot <= next_slot(cur_slot, rate_sel);
            end else begin
                nxt_bit  <= cur_bit + 1'b1;
                nxt_slot <= cur_slot;
            end
        end
    end
endmodule

// File: rtl/tdm_chan_mapper.sv
// Issues one byte fetch per slot for the following slot, rotating the
// channel number by the stream delay modulo the channel count.
module tdm_chan_mapper
    import tdm_dly_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [BIT_W-1:0]  cur_bit,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [SLOT_W-1:0] ch_delay,
    output logic              fetch_req,
    output logic [SLOT_W-1:0] fetch_chan
);
    logic [SLOT_W-1:0] upcoming;
    logic [SLOT_W-1:0] rotated;

    // Channel to fetch for the slot after the current one.
    always_comb begin
        upcoming = next_slot(cur_slot, rate_sel);
        rotated  = (upcoming - ch_delay) & slot_mask(rate_sel);
    end

    // Register the fetch strobe and channel at the mid-slot fetch point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_req  <= 1'b0;
            fetch_chan <= '0;
        end else begin
            fetch_req <= bit_en && (cur_bit == BIT_W'(FETCH_BIT));
            if (bit_en && (cur_bit == BIT_W'(FETCH_BIT))) begin
                fetch_chan <= rotated;
            end
        end
    end
endmodule

// File: rtl/tdm_byte_shifter.sv
// Holds the prefetched byte and shifts the active byte out MSB first.
// Assumes fetch_data is valid in the cycle fetch_req is high.
module tdm_byte_shifter
    import tdm_dly_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [BIT_W-1:0]  cur_bit,
    input  logic              fetch_req,
    input  logic [BYTE_W-1:0] fetch_data,
    output logic [BYTE_W-1:0] pend_byte,
    output logic              ser_out
);
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] load_byte;

    // A byte arriving now wins over the stored one at a slot start.
    always_comb begin
        load_byte = fetch_req ? fetch_data : pend_byte;
    end

    // Capture the prefetched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_byte <= '0;
        end else if (fetch_req) begin
            pend_byte <= fetch_data;
        end
    end

    // Load at slot start, otherwise shift one bit per enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            ser_out <= 1'b0;
        end else if (bit_en) begin
            if (cur_bit == '0) begin
                ser_out <= load_byte[BYTE_W-1];
                shreg   <= {load_byte[BYTE_W-2:0], 1'b0};
            end else begin
                ser_out <= shreg[BYTE_W-1];
                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/tdm_chdly_serializer.sv
// Top: serializes channel bytes onto one TDM stream with a programmable
// channel delay against the output frame boundary.
module tdm_chdly_serializer
    import tdm_dly_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_pulse,
    input  logic [1:0]        rate_sel,
    input  logic [6:0]        ch_delay,
    output logic              fetch_req,
    output logic [6:0]        fetch_chan,
    input  logic [7:0]        fetch_data,
    output logic              ser_out
);
    logic [BIT_W-1:0]  cur_bit;
    logic [SLOT_W-1:0] cur_slot;
    logic [BYTE_W-1:0] pend_byte;

    tdm_slot_timer u_timer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_pulse(frame_pulse),
        .rate_sel(rate_sel), .cur_bit(cur_bit), .cur_slot(cur_slot)
    );

    tdm_chan_mapper u_mapper (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cur_bit(cur_bit),
        .cur_slot(cur_slot), .rate_sel(rate_sel), .ch_delay(ch_delay),
        .fetch_req(fetch_req), .fetch_chan(fetch_chan)
    );

    tdm_byte_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cur_bit(cur_bit),
        .fetch_req(fetch_req), .fetch_data(fetch_data),
        .pend_byte(pend_byte), .ser_out(ser_out)
    );
endmodule

// File: rtl/tdm_chdly_checker.sv
// Temporal checks on the serializer ports and its prefetch register.
module tdm_chdly_checker
    import tdm_dly_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       frame_pulse,
    input logic [1:0] rate_sel,
    input logic       fetch_req,
    input logic [6:0] fetch_chan,
    input logic [7:0] fetch_data,
    input logic [7:0] pend_byte,
    input logic       ser_out
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!ser_out && !fetch_req));

    assert_hold_without_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ser_out));

    assert_fetch_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    assert_fetch_after_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> $past(bit_en));

    assert_chan_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && $stable(rate_sel)) |-> (fetch_chan <= slot_mask(rate_sel)));

    assert_frame_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_pulse && !fetch_req) |=> (ser_out == $past(pend_byte[7])));

    assert_collision_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_pulse && fetch_req) |=> (ser_out == $past(fetch_data[7])));
endmodule

bind tdm_chdly_serializer tdm_chdly_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_pulse(frame_pulse),
    .rate_sel(rate_sel), .fetch_req(fetch_req), .fetch_chan(fetch_chan),
    .fetch_data(fetch_data), .pend_byte(pend_byte), .ser_out(ser_out)
);

// File: tb/sim_tdm_chdly_serializer.sv
module sim_tdm_chdly_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       frame_pulse = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [6:0] ch_delay = 7'd0;
    logic       fetch_req;
    logic [6:0] fetch_chan;
    logic [7:0] fetch_data;
    logic       ser_out;

    int n_cmp = 0;
    int n_bad = 0;
    int seed = 1;
    bit done = 1'b0;
    bit live = 1'b0;
    string tag = "R1";

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input int ch, input int sd);
        return 8'(((ch * 29) + (sd * 7) + 3) ^ (sd << 4));
    endfunction

    assign fetch_data = pat(int'(fetch_chan), seed);

    tdm_chdly_serializer u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_pulse(frame_pulse),
        .rate_sel(rate_sel), .ch_delay(ch_delay), .fetch_req(fetch_req),
        .fetch_chan(fetch_chan), .fetch_data(fetch_data), .ser_out(ser_out)
    );

    // Reference model: frame position as integers, bytes as plain values.
    int         m_nbit = 0, m_nslot = 0, m_chan = 0;
    logic [7:0] m_sh = 0, m_pend = 0;
    bit         m_out = 0, m_req = 0;

    always @(posedge clk) begin
        int cb, cs, ns, cnt;
        bit nreq;
        if (!rst_n) begin
            m_nbit = 0; m_nslot = 0; m_chan = 0;
            m_sh = 0; m_pend = 0; m_out = 0; m_req = 0;
        end else begin
            if (m_req) m_pend = pat(m_chan, seed);
            nreq = 0;
            if (bit_en) begin
                cnt = (rate_sel == 0) ? 32 : (rate_sel == 1) ? 64 : 128;
                cb  = frame_pulse ? 0 : m_nbit;
                cs  = frame_pulse ? 0 : m_nslot;
                if (cb == 0) begin
                    m_out = m_pend[7];
                    m_sh  = m_pend << 1;
                end else begin
                    m_out = m_sh[7];
                    m_sh  = m_sh << 1;
                end
                ns = (cs >= cnt - 1) ? 0 : cs + 1;
                if (cb == 3) begin
                    nreq   = 1;
                    m_chan = (((ns - int'(ch_delay)) % cnt) + cnt) % cnt;
                end
                if (cb == 7) begin m_nbit = 0; m_nslot = ns; end
                else begin m_nbit = cb + 1; m_nslot = cs; end
            end
            m_req = nreq;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (live && !done) begin
            n_cmp++;
            if (ser_out !== m_out) begin
                n_bad++;
                $display("FAIL %s ser_out actual=%0d expected=%0d t=%0t", tag, ser_out, m_out, $time);
            end
            n_cmp++;
            if (fetch_req !== m_req) begin
                n_bad++;
                $display("FAIL %s/R6 fetch_req actual=%0d expected=%0d t=%0t", tag, fetch_req, m_req, $time);
            end
            if (m_req) begin
                n_cmp++;
                if (int'(fetch_chan) != m_chan) begin
                    n_bad++;
                    $display("FAIL %s/R6 fetch_chan actual=%0d expected=%0d t=%0t", tag, fetch_chan, m_chan, $time);
                end
            end
        end
    end

    task automatic run_bits(input int nbits, input int en_per, input int pulse_per, input bit pulses);
        int cnt = 0;
        int cyc = 0;
        while (cnt < nbits) begin
            @(negedge clk);
            bit_en      <= (cyc % en_per == 0);
            frame_pulse <= (cyc % en_per == 0) && pulses && (cnt % pulse_per == 0);
            if (cyc % en_per == 0) cnt++;
            cyc++;
        end
        @(negedge clk);
        bit_en      <= 1'b0;
        frame_pulse <= 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        live = 1'b1;
        tag  = "R1";                               // reset state compared here
        repeat (2) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        tag = "R3";                                // delay 0, 32 channels
        rate_sel <= 2'd0; ch_delay <= 7'd0; seed = 2;
        run_bits(3 * 256, 1, 256, 1'b1);
        tag = "R4";                                // delay 5, 64 channels, sparse enable (R2)
        rate_sel <= 2'd1; ch_delay <= 7'd5; seed = 3;
        run_bits(2 * 512, 3, 512, 1'b1);
        tag = "R4";                                // delay 127, 128 channels
        rate_sel <= 2'd2; ch_delay <= 7'd127; seed = 4;
        run_bits(2 * 1024, 1, 1024, 1'b1);
        tag = "R5";                                // 100 acts as 4 at 32 channels
        rate_sel <= 2'd0; ch_delay <= 7'd100; seed = 5;
        run_bits(2 * 256, 2, 256, 1'b1);
        tag = "R8";                                // free-running wrap without pulses
        ch_delay <= 7'd1;
        run_bits(3 * 256, 1, 256, 1'b0);
        tag = "R9";                                // rate drop mid-frame forces wrap
        rate_sel <= 2'd2; ch_delay <= 7'd9; seed = 6;
        run_bits(700, 1, 1024, 1'b1);
        rate_sel <= 2'd0;
        run_bits(600, 1, 256, 1'b0);
        tag = "R7";                                // re-align to a fresh boundary
        rate_sel <= 2'd1; ch_delay <= 7'd2; seed = 7;
        run_bits(2 * 512, 1, 512, 1'b1);
        tag = "R10";                               // pulse one bit after a fetch point
        run_bits(6 * 84, 1, 84, 1'b1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule